// File: doc/BRIEF.md
# Bytewide EEPROM Control-Pin Front End

This block sits between the asynchronous control pins of a bytewide parallel EEPROM and its synchronous internals. It samples three active-low enables (chip, output, write), an 11-bit address and an 8-bit data bus on one fast clock. Short pulses on the enables are suppressed by a per-pin persistence filter. The surviving levels are decoded into a read-drive enable for the data bus and into write events.

A write spans the interval in which chip enable and write enable are both low while output enable is high. The address belongs to the moment the second of the two enables falls. The data belongs to the moment the first of them rises. Each accepted write leaves the block as a single-cycle event that carries both values.

A supply-good input gates everything. Reads wait for a short settling time after it rises, and writes wait for a much longer one. If supply-good drops, both timers restart from zero and any write in progress is abandoned.

Top module: `ee_bus_front`

## Requirements
- R1: `dq_oe` is 1 only while the filtered pins show chip enable low, output enable low and write enable high, and the read delay has elapsed. It returns to 0 when output enable or chip enable goes high.
- R2: After `pwr_good` rises, `dq_oe` stays 0 until `pwr_good` has been sampled high for RD_DELAY_US microseconds of clock cycles.
- R3: A write is recognised only while chip enable and write enable are low and output enable is high. Holding output enable low during such a pulse yields no write event.
- R4: `wr_addr` is the value on `addr` in the clock where the later of chip enable or write enable is first seen low. This holds for both write-enable-controlled and chip-enable-controlled cycles, and later address changes are ignored.
- R5: `wr_data` is the value on `din` in the clock where the earlier of chip enable or write enable is first seen high. Later data changes are ignored.
- R6: Every accepted write produces exactly one `wr_valid` pulse, one cycle wide.
- R7: A low pulse on chip enable or write enable that lasts fewer than FILT_CYC clocks (10 ns worth, rounded up) produces no write. A pulse of exactly FILT_CYC clocks is accepted.
- R8: A write whose start comes before `pwr_good` has been high for WR_DELAY_US microseconds of cycles produces no event.
- R9: Sampling `pwr_good` low clears `dq_oe` and `wr_valid` on the next cycle, abandons any open write and restarts both delays.
- R10: After reset, `dq_oe` and `wr_valid` are 0 and `wr_addr` and `wr_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply-good indication |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Data bus input |
| dq_oe | output | 1 | Drive enable for the data bus output buffers |
| wr_valid | output | 1 | One-cycle write event |
| wr_addr | output | 11 | Address of the latest write event |
| wr_data | output | 8 | Data of the latest write event |

## Verification
Write cycles are run both with write enable falling and rising inside a held chip enable, and the reverse. The address and data are changed right after their capture points, which separates correct edge selection from sampling at the wrong end of the pulse. One-clock glitches on each enable are set against pulses of exactly the filter length, to pin the acceptance threshold. Writes issued just before and after the lockout expires, and after a brief supply-good dropout, tell apart the power-up hold-off from ordinary write handling. Read-mode drive is observed before and after its own shorter delay.

// File: rtl/ee_bus_front.sv
module ee_bus_front #(
  parameter int CLK_MHZ     = 200,
  parameter int GLITCH_NS   = 10,
  parameter int RD_DELAY_US = 1,
  parameter int WR_DELAY_US = 10000,
  parameter int AW          = 11,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          dq_oe,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  localparam int FILT_RAW = (CLK_MHZ * GLITCH_NS + 999) / 1000;
  localparam int FILT_CYC = (FILT_RAW < 1) ? 1 : FILT_RAW;
  localparam int FC_W     = $clog2(FILT_CYC + 1);
  localparam int RD_CYC   = CLK_MHZ * RD_DELAY_US;
  localparam int WR_CYC   = CLK_MHZ * WR_DELAY_US;
  localparam int PU_MAX   = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int PU_W     = $clog2(PU_MAX + 1);

  // pin order: [2]=ce, [1]=oe, [0]=we
  logic [2:0] raw_pins, flt;
  assign raw_pins = {ce_n, oe_n, we_n};

  for (genvar i = 0; i < 3; i++) begin : g_filt
    logic [FC_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt    <= '0;
        flt[i] <= 1'b1;
      end else if (raw_pins[i] == flt[i]) begin
        cnt <= '0;
      end else if (cnt == FC_W'(FILT_CYC - 1)) begin
        cnt    <= '0;
        flt[i] <= raw_pins[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic f_ce, f_oe, f_we;
  assign f_ce = flt[2];
  assign f_oe = flt[1];
  assign f_we = flt[0];

  // bus delay matching the filter latency
  logic [AW-1:0] a_pipe [FILT_CYC];
  logic [DW-1:0] d_pipe [FILT_CYC];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < FILT_CYC; j++) begin
        a_pipe[j] <= '0;
        d_pipe[j] <= '0;
      end
    end else begin
      a_pipe[0] <= addr;
      d_pipe[0] <= din;
      for (int j = 1; j < FILT_CYC; j++) begin
        a_pipe[j] <= a_pipe[j-1];
        d_pipe[j] <= d_pipe[j-1];
      end
    end
  end

  logic [AW-1:0] addr_d;
  logic [DW-1:0] data_d;
  assign addr_d = a_pipe[FILT_CYC-1];
  assign data_d = d_pipe[FILT_CYC-1];

  logic [PU_W-1:0] pu_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pu_cnt <= '0;
    else if (!pwr_good)               pu_cnt <= '0;
    else if (pu_cnt != PU_W'(PU_MAX)) pu_cnt <= pu_cnt + 1'b1;
  end

  logic rd_ok, wr_ok;
  assign rd_ok = pu_cnt >= PU_W'(RD_CYC);
  assign wr_ok = pu_cnt >= PU_W'(WR_CYC);

  logic rd_mode, wr_act, wr_act_q, arm;
  logic [AW-1:0] a_lat;
  assign rd_mode = !f_ce && !f_oe && f_we;
  assign wr_act  = !f_ce && !f_we && f_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe    <= 1'b0;
      wr_act_q <= 1'b0;
      arm      <= 1'b0;
      a_lat    <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      dq_oe    <= rd_mode && rd_ok && pwr_good;
      wr_act_q <= wr_act;
      wr_valid <= 1'b0;
      if (wr_act && !wr_act_q) begin
        arm   <= wr_ok && pwr_good;
        a_lat <= addr_d;
      end else if (!wr_act && wr_act_q) begin
        arm <= 1'b0;
        if (arm && pwr_good) begin
          wr_valid <= 1'b1;
          wr_addr  <= a_lat;
          wr_data  <= data_d;
        end
      end else if (!pwr_good) begin
        arm <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ee_bus_front_chk.sv
module ee_bus_front_chk #(
  parameter int RD_CYC = 200,
  parameter int WR_CYC = 2000000
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic dq_oe,
  input logic wr_valid
);
  localparam int CW = $clog2(WR_CYC + 1);
  logic [CW-1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     up_cnt <= '0;
    else if (!pwr_good)             up_cnt <= '0;
    else if (up_cnt != CW'(WR_CYC)) up_cnt <= up_cnt + 1'b1;
  end

  AST_RD_WAIT:   assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> up_cnt >= CW'(RD_CYC));   // R2
  AST_WR_LOCK:   assert property (@(posedge clk) disable iff (!rst_n) wr_valid |-> up_cnt == CW'(WR_CYC)); // R8
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |=> !wr_valid);             // R6
  AST_RD_DROP:   assert property (@(posedge clk) disable iff (!rst_n) !pwr_good |=> !dq_oe);               // R9
  AST_WR_DROP:   assert property (@(posedge clk) disable iff (!rst_n) !pwr_good |=> !wr_valid);            // R9
endmodule

bind ee_bus_front ee_bus_front_chk #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .dq_oe(dq_oe), .wr_valid(wr_valid)
);

// File: tb/sim_ee_bus_front.sv
module sim_ee_bus_front;
  localparam int N = 2;
  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic dq_oe, wr_valid;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0, fails = 0;
  bit done = 0, prev_v = 0;
  logic [18:0] exp_q [$];

  always #2.5 clk = ~clk;

  ee_bus_front #(.WR_DELAY_US(3)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dq_oe(dq_oe), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // later pin falls at capture of address; same pin rises first
  task automatic wr(input logic [10:0] a, input logic [7:0] d, input bit ce_ctl, input bit ev, input int len);
    if (ev) exp_q.push_back({a, d});
    @(negedge clk); addr = a; din = d; oe_n = 1'b1;
    if (ce_ctl) we_n = 1'b0; else ce_n = 1'b0;
    idle(3);
    if (ce_ctl) ce_n = 1'b0; else we_n = 1'b0;
    idle(1); addr = ~a;
    idle(len - 1);
    if (ce_ctl) ce_n = 1'b1; else we_n = 1'b1;
    idle(1); din = ~d;
    idle(3);
    ce_n = 1'b1; we_n = 1'b1;
    idle(8);
  endtask

  task automatic glitch(input bit on_ce);
    @(negedge clk); oe_n = 1'b1;
    if (on_ce) we_n = 1'b0; else ce_n = 1'b0;
    idle(3);
    if (on_ce) ce_n = 1'b0; else we_n = 1'b0;
    idle(1);
    if (on_ce) ce_n = 1'b1; else we_n = 1'b1;
    idle(3);
    ce_n = 1'b1; we_n = 1'b1;
    idle(8);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_valid) begin
        chk(!prev_v, "R6 pulse width", 2, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R7/R8/R9 unexpected write", int'({wr_addr, wr_data}), 0);
        end else begin
          logic [18:0] e;
          e = exp_q.pop_front();
          chk(wr_addr == e[18:8], "R4 address", int'(wr_addr), int'(e[18:8]));
          chk(wr_data == e[7:0], "R5 data", int'(wr_data), int'(e[7:0]));
        end
      end
      prev_v = wr_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(dq_oe == 1'b0 && wr_valid == 1'b0, "R10 reset flags", int'({dq_oe, wr_valid}), 0);
    chk(wr_addr == '0 && wr_data == '0, "R10 reset bus", int'({wr_addr, wr_data}), 0);
    rst_n = 1'b1;
    idle(2);
    pwr_good = 1'b1;
    ce_n = 1'b0; oe_n = 1'b0;
    idle(50);
    chk(dq_oe == 1'b0, "R2 read held off", int'(dq_oe), 0);
    idle(200);
    chk(dq_oe == 1'b1, "R1 read drive", int'(dq_oe), 1);
    oe_n = 1'b1; idle(N + 2);
    chk(dq_oe == 1'b0, "R1 oe high", int'(dq_oe), 0);
    oe_n = 1'b0; idle(N + 2);
    chk(dq_oe == 1'b1, "R1 read again", int'(dq_oe), 1);
    ce_n = 1'b1; idle(N + 2);
    chk(dq_oe == 1'b0, "R1 ce high", int'(dq_oe), 0);
    oe_n = 1'b1;
    // early write inside lockout: R8
    wr(11'h123, 8'h45, 1'b0, 1'b0, 4);
    idle(350);
    wr(11'h555, 8'hAA, 1'b0, 1'b1, 4);   // write-enable controlled
    wr(11'h2AA, 8'h55, 1'b1, 1'b1, 4);   // chip-enable controlled
    wr(11'h7FF, 8'h00, 1'b0, 1'b1, N);   // R7 boundary: exactly N cycles
    wr(11'h001, 8'hFF, 1'b1, 1'b1, N);
    glitch(1'b0);                        // R7 write enable glitch
    glitch(1'b1);                        // R7 chip enable glitch
    // R3: output enable low during pulse
    @(negedge clk); oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; addr = 11'h0F0; din = 8'h0F;
    idle(6);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    idle(8);
    // R9: supply dropout
    ce_n = 1'b0; oe_n = 1'b0; idle(N + 2);
    chk(dq_oe == 1'b1, "R1 read before drop", int'(dq_oe), 1);
    pwr_good = 1'b0; idle(2);
    chk(dq_oe == 1'b0, "R9 read cleared", int'(dq_oe), 0);
    pwr_good = 1'b1; idle(5);
    chk(dq_oe == 1'b0, "R9 read delay restarted", int'(dq_oe), 0);
    ce_n = 1'b1; oe_n = 1'b1;
    wr(11'h333, 8'h33, 1'b0, 1'b0, 4);
    idle(620);
    wr(11'h444, 8'h5A, 1'b1, 1'b1, 4);
    idle(10);
    chk(exp_q.size() == 0, "R6 missing write events", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule